// File: doc/BRIEF.md
# Trace Record Formatter

This block turns one captured transaction-layer packet header into a fixed-length trace record and sends that record out as a stream of 32-bit words. Each header is four dwords. It comes with an optional prefix dword and a timestamp. A format register picks one of two record layouts. The compact layout is four words long. It squeezes the routing-relevant fields of header dword 0 together with the low bits of the timestamp. The long layout is eight words long. It begins with an all-ones marker word and carries the full header, the prefix and the full timestamp.

Headers arrive on a valid/ready input. The block takes one header, then streams its record on a valid/ready output with a last flag on the final word. It takes no further header until the record has gone out completely.

Top module: `trace_rec_fmt`

## Requirements
- R1: After reset the format register holds code 0, so records are 4 words long. In the idle state hdr_ready is 1 and out_valid is 0.
- R2: A write of code 1 to the format register selects 8-word records. Any other code selects 4-word records. A write takes effect for the next header accepted.
- R3: A header is accepted on a cycle with hdr_valid and hdr_ready both high. out_valid rises on the next cycle. hdr_ready stays low from then until the cycle after the handshake of the last word.
- R4: In an 8-word record, word 0 is 32'hFFFF_FFFF.
- R5: In an 8-word record, word 1 is pfx_data when pfx_present was high at acceptance, and 0 otherwise. Word 6 is 0.
- R6: In an 8-word record, words 2 to 5 are header dwords 0 to 3, with dword n at hdr_data[32n+31:32n]. Word 7 is the timestamp, zero-extended.
- R7: In a 4-word record, word 0 is built from header dword 0 (d) and the timestamp (t) as {d[30:29], d[28:24], d[23], d[19], d[16], d[13], d[9:0], t[10:0]}, from MSB to LSB.
- R8: In a 4-word record, words 1 to 3 are header dwords 1 to 3, unchanged.
- R9: out_last is high only on the final word: word 3 of a 4-word record and word 7 of an 8-word record.
- R10: While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R11: The header, prefix, timestamp and format are sampled at acceptance. Later changes on those inputs, or a format write, do not alter a record already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_wr_en | input | 1 | Format register write strobe |
| fmt_wr_code | input | FMT_W (4) | Format code to write |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block can accept a header |
| hdr_data | input | 128 | Header dwords, dword n at bits 32n+31:32n |
| pfx_present | input | 1 | A prefix dword accompanies the header |
| pfx_data | input | 32 | Prefix dword |
| timestamp | input | TS_W (32) | Free-running timestamp |
| out_valid | output | 1 | Record word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Record word |
| out_last | output | 1 | Final word of the record |

## Verification
The assertions assume that the consumer may stall out_ready at any cycle. They also assume that hdr_valid may be held high across a busy record, so acceptance is judged only from the handshake at the input. The stimulus drives every input shortly after the rising edge and samples outputs on the falling edge. It mixes a continuously ready consumer with an irregular one, so that the hold checks on stalled words are exercised. Format writes and changes to the timestamp are issued while a record is still streaming, to test R11.

// File: rtl/trc_pkg.sv
// Shared constants for the trace record formatter.
// Assumes 32-bit record words and a four-dword captured header.
package trc_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HDR_WORDS  = 4;
    localparam int unsigned HDR_W      = WORD_W * HDR_WORDS;
    localparam int unsigned SHORT_LEN  = 4;
    localparam int unsigned LONG_LEN   = 8;
    localparam int unsigned IDX_W      = $clog2(LONG_LEN);
    localparam int unsigned STAMP_BITS = 11;
    localparam logic [WORD_W-1:0] MARKER = '1;
endpackage

// File: rtl/trc_word_builder.sv
// Pure combinational word selector: given the captured header, prefix,
// timestamp and layout, returns the record word at position idx.
// Assumes TS_W lies between STAMP_BITS and WORD_W.
module trc_word_builder
    import trc_pkg::*;
#(
    parameter int unsigned TS_W = 32
) (
    input  logic                 long_fmt,
    input  logic [IDX_W-1:0]     idx,
    input  logic [HDR_W-1:0]     hdr,
    input  logic [WORD_W-1:0]    pfx,
    input  logic [TS_W-1:0]      ts,
    output logic [WORD_W-1:0]    word
);
    logic [WORD_W-1:0] dw [HDR_WORDS];
    logic [WORD_W-1:0] ts_ext;
    logic [WORD_W-1:0] compact0;

    // Slice the header into dwords.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_split
        assign dw[g] = hdr[g*WORD_W +: WORD_W];
    end

    // Zero-extend timestamp to a full word.
    always_comb ts_ext = WORD_W'(ts);

    // Pack selected header fields with the truncated timestamp.
    always_comb compact0 = {dw[0][30:29], dw[0][28:24], dw[0][23], dw[0][19],
                            dw[0][16], dw[0][13], dw[0][9:0], ts[STAMP_BITS-1:0]};

    // Choose the word for the current position and layout.
    always_comb begin
        word = '0;
        if (long_fmt) begin
            case (idx)
                3'd0: word = MARKER;
                3'd1: word = pfx;
                3'd2: word = dw[0];
                3'd3: word = dw[1];
                3'd4: word = dw[2];
                3'd5: word = dw[3];
                3'd6: word = '0;
                default: word = ts_ext;
            endcase
        end else begin
            case (idx)
                3'd0: word = compact0;
                3'd1: word = dw[1];
                3'd2: word = dw[2];
                3'd3: word = dw[3];
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/trc_stream_seq.sv
// Word sequencer: on start it latches the layout and walks the word index
// from 0 to the final position, advancing on each output handshake.
// Assumes start is raised only while not busy.
module trc_stream_seq
    import trc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             long_in,
    input  logic             out_ready,
    output logic             busy,
    output logic             long_q,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] SHORT_END = IDX_W'(SHORT_LEN - 1);
    localparam logic [IDX_W-1:0] LONG_END  = IDX_W'(LONG_LEN - 1);

    // Final word flag for the active layout.
    always_comb last = busy && (idx == (long_q ? LONG_END : SHORT_END));

    // Track record progress and the latched layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            long_q <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            long_q <= long_in;
            idx    <= '0;
        end else if (busy && out_ready) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/trace_rec_fmt.sv
// Trace record formatter top: holds the format register, captures one
// header with its prefix and timestamp, and streams the record.
// Assumes the downstream consumer obeys valid/ready.
module trace_rec_fmt
    import trc_pkg::*;
#(
    parameter int unsigned FMT_W  = 4,
    parameter int unsigned TS_W   = 32,
    parameter int unsigned LONG_CODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_wr_en,
    input  logic [FMT_W-1:0]  fmt_wr_code,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [HDR_W-1:0]  hdr_data,
    input  logic              pfx_present,
    input  logic [WORD_W-1:0] pfx_data,
    input  logic [TS_W-1:0]   timestamp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    logic [FMT_W-1:0]  fmt_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [WORD_W-1:0] pfx_q;
    logic [TS_W-1:0]   ts_q;
    logic              busy, long_q, accept;
    logic [IDX_W-1:0]  idx;

    // Input handshake.
    always_comb begin
        hdr_ready = !busy;
        accept    = hdr_valid && !busy;
    end

    // Format register, reset to the compact layout.
    always_ff @(posedge clk) begin
        if (!rst_n)         fmt_q <= '0;
        else if (fmt_wr_en) fmt_q <= fmt_wr_code;
    end

    // Capture header, prefix and timestamp at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            pfx_q <= '0;
            ts_q  <= '0;
        end else if (accept) begin
            hdr_q <= hdr_data;
            pfx_q <= pfx_present ? pfx_data : '0;
            ts_q  <= timestamp;
        end
    end

    trc_stream_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .long_in   (fmt_q == FMT_W'(LONG_CODE)),
        .out_ready (out_ready),
        .busy      (busy),
        .long_q    (long_q),
        .idx       (idx),
        .last      (out_last)
    );

    trc_word_builder #(.TS_W(TS_W)) u_build (
        .long_fmt (long_q),
        .idx      (idx),
        .hdr      (hdr_q),
        .pfx      (pfx_q),
        .ts       (ts_q),
        .word     (out_data)
    );

    // Output valid follows the record in flight.
    always_comb out_valid = busy;
endmodule

// File: rtl/trc_fmt_chk.sv
// Protocol checker for trace_rec_fmt, attached by bind.
// Counts output beats within a record to check the last-word position.
module trc_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hdr_valid,
    input logic        hdr_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last
);
    logic [3:0] beat;

    // Beat counter within the current record.
    always_ff @(posedge clk) begin
        if (!rst_n) beat <= '0;
        else if (out_valid && out_ready) beat <= out_last ? 4'd0 : beat + 4'd1;
    end

    p_no_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hdr_ready);
    p_start_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> out_valid);
    p_idle_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (hdr_ready && !out_valid));
    p_last_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (beat == 4'd3 || beat == 4'd7));
    p_beat_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (beat <= 4'd7));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind trace_rec_fmt trc_fmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/trace_rec_fmt_tb_top.sv
// Scoreboard bench: the driver queues expected words, the monitor compares.
module trace_rec_fmt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_wr_en = 1'b0;
    logic [3:0]   fmt_wr_code = '0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [127:0] hdr_data = '0;
    logic         pfx_present = 1'b0;
    logic [31:0]  pfx_data = '0;
    logic [31:0]  timestamp = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;
    logic         out_last;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  rand_ready = 1'b0;
    logic [3:0] fmt_model = '0;
    logic [32:0] exp_q[$];   // {last, word}
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_rec_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_wr_en(fmt_wr_en), .fmt_wr_code(fmt_wr_code),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
        .pfx_present(pfx_present), .pfx_data(pfx_data), .timestamp(timestamp),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input bit last, input string req);
        exp_q.push_back({last, w});
        tag_q.push_back(req);
    endtask

    task automatic write_fmt(input logic [3:0] code);
        @(posedge clk); #1;
        fmt_wr_en = 1'b1; fmt_wr_code = code;
        @(posedge clk); #1;
        fmt_wr_en = 1'b0;
        fmt_model = code;
    endtask

    // Offer one header, wait for acceptance, queue the expected record.
    task automatic send(input logic [127:0] h, input bit pp, input logic [31:0] pd,
                        input logic [31:0] ts);
        logic [31:0] d0;
        bit long_f;
        @(posedge clk); #1;
        hdr_data = h; pfx_present = pp; pfx_data = pd; timestamp = ts; hdr_valid = 1'b1;
        do @(negedge clk); while (!hdr_ready);
        long_f = (fmt_model == 4'd1);
        d0 = h[31:0];
        if (long_f) begin
            push(32'hFFFF_FFFF, 0, "R4 marker");
            push(pp ? pd : 32'h0, 0, "R5 prefix");
            push(h[31:0],   0, "R6 hdr0");
            push(h[63:32],  0, "R6 hdr1");
            push(h[95:64],  0, "R6 hdr2");
            push(h[127:96], 0, "R6 hdr3");
            push(32'h0,     0, "R5 zero word");
            push(ts,        1, "R6/R9 time last");
        end else begin
            push({d0[30:29], d0[28:24], d0[23], d0[19], d0[16], d0[13], d0[9:0], ts[10:0]},
                 0, "R7 packed");
            push(h[63:32],  0, "R8 hdr1");
            push(h[95:64],  0, "R8 hdr2");
            push(h[127:96], 1, "R8/R9 hdr3 last");
        end
        @(posedge clk); #1;
        hdr_valid = 1'b0;
        // R11: disturb the sampled inputs while the record streams.
        hdr_data = ~h; pfx_data = ~pd; timestamp = ts + 32'h1357;
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 200) begin
            @(negedge clk); guard++;
        end
    endtask

    // Consumer ready: steady or irregular, changed just after the edge.
    always @(posedge clk) begin
        #1;
        out_ready <= rand_ready ? ($urandom % 3 != 0) : 1'b1;
    end

    // Monitor: compare every handshaked word with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected word", {out_last, out_data}, 33'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_last, out_data} === e, t, {out_last, out_data}, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 33'h0, 33'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hdr_ready === 1'b1, "R1 ready after reset", {32'h0, hdr_ready}, 33'h1);
        check(out_valid === 1'b0, "R1 idle after reset", {32'h0, out_valid}, 33'h0);

        // R1: default compact format
        send({32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h6A89_A3FF}, 1'b1,
             32'hDEAD_BEEF, 32'h0000_0ABC);
        @(negedge clk);
        // R3 input blocked while streaming
        check(hdr_ready === 1'b0, "R3 ready low in flight", {32'h0, hdr_ready}, 33'h0);
        drain();

        // R2: long format with prefix
        write_fmt(4'd1);
        send({32'hA0A0_0003, 32'hB1B1_0002, 32'hC2C2_0001, 32'h4000_0010}, 1'b1,
             32'h1234_5678, 32'hCAFE_F00D);
        write_fmt(4'd0);   // R11 write in flight must not alter this record
        drain();
        // R2 compact again after write of code 0
        send({32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF}, 1'b0, 32'h0, 32'hFFFF_FFFF);
        drain();

        // R5: long format without prefix, irregular consumer (R10)
        write_fmt(4'd1);
        rand_ready = 1'b1;
        send({32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h8000_0001}, 1'b0,
             32'h5555_5555, 32'h0007_FFFF);
        drain();
        // R2: unsupported code falls back to compact
        write_fmt(4'd7);
        for (int i = 0; i < 4; i++) begin
            send({$urandom, $urandom, $urandom, $urandom}, i[0], $urandom, $urandom);
        end
        drain();
        write_fmt(4'd1);
        for (int i = 0; i < 3; i++) begin
            send({$urandom, $urandom, $urandom, $urandom}, i[0], $urandom, $urandom);
        end
        drain();
        rand_ready = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R9 all words delivered", 33'(exp_q.size()), 33'h0);
        check(hdr_ready === 1'b1, "R3 ready after record", {32'h0, hdr_ready}, 33'h1);
        finish_run();
    end
endmodule